// File: doc/BRIEF.md
# Single-Port Word RAM with XOR Column Merge

This block stores 2^ADDR_W words of DATA_W bits each and serves one access per clock. A one-hot row decoder turns the address into row select lines. Each row line is ANDed with the write enable to form that row's load strobe. Every row presents its stored word masked by its own select line. A per-column XOR reduction across all rows merges these masked words into the read word. The merge is correct because exactly one row is selected at any time. It needs no multiplexer tree.

A write loads the full word into the addressed row. A read places the addressed word in a registered output one clock later. During the read, the addressed row is reloaded with its own contents. Rows that are not addressed keep their contents whatever the write enable and data inputs do. A synchronous active-high reset clears every word and the output register.

Top module: `word_ram`

## Requirements
- R1: For one cycle after reset is deasserted, `rd_data` is 0. A read of any address after reset, with no write in between, returns 0.
- R2: When `wr_en` is 1 at a rising edge, the row selected by `addr` is loaded with `wr_data`.
- R3: When `wr_en` is 0 at a rising edge, `rd_data` shows the word stored at `addr` from that edge on, that is, one cycle after the address is applied.
- R4: A read leaves the addressed word unchanged, so reading the same address again returns the same word.
- R5: A write changes only the addressed word. Every other address keeps its contents.
- R6: `rd_data` keeps its previous value through any cycle in which `wr_en` is 1.
- R7: Each address value selects exactly one row, and distinct addresses select distinct rows. Words written to all addresses are all returned intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address |
| wr_en | input | 1 | 1 = write, 0 = read with refresh |
| wr_data | input | DATA_W | Word to store on a write |
| rd_data | output | DATA_W | Registered read word |

## Verification
The bench first fills every address with a different value derived from the address, then reads all addresses back. If the decoder aliased two rows, or the XOR merge picked up an unselected row, a word would come back corrupted. Walking-one, alternating-bit and all-ones words then exercise every column of the merge with both polarities. A single write followed by a sweep of all addresses shows whether the load strobe leaks into neighbouring rows. Repeated reads show whether the refresh path preserves data. A read followed by a write shows whether the output register holds during the write.

// File: rtl/ram_pkg.sv
package ram_pkg;

    localparam int ADDR_W_DEF = 4;
    localparam int DATA_W_DEF = 8;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } ram_op_e;

    // Decode a binary index into a one-hot vector of width 2**aw (aw <= 16).
    function automatic logic [65535:0] onehot_of(input logic [15:0] idx, input int aw);
        logic [65535:0] v;
        v = '0;
        if (aw > 0) v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/row_decoder.sv
module row_decoder #(
    parameter int ADDR_W = ram_pkg::ADDR_W_DEF,
    localparam int ROWS = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ROWS-1:0]   sel_o
);

    for (genvar r = 0; r < ROWS; r++) begin : g_line
        assign sel_o[r] = (addr_i == ADDR_W'(r));
    end

    // R7: exactly one row line is active for any known address
    always_comb begin
        if (!$isunknown(addr_i)) begin
            p_onehot_sel_r7: assert ($onehot(sel_o))
                else $error("row select not one-hot");
        end
    end

endmodule

// File: rtl/ram_row.sv
module ram_row #(
    parameter int DATA_W = ram_pkg::DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] tap_o
);

    logic              load;
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] word_d;

    // Row strobe: row line AND write enable.
    assign load = sel_i & wr_i;

    // Each cell takes either the incoming bit or its own bit (refresh/hold).
    for (genvar b = 0; b < DATA_W; b++) begin : g_cell
        assign word_d[b] = load ? d_i[b] : word_q[b];
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_d;
    end

    // Only the selected row contributes to the column merge.
    assign tap_o = word_q & {DATA_W{sel_i}};

    // R2: a strobed row holds the written data afterwards
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (sel_i && wr_i) |=> (tap_o | ~{DATA_W{sel_i}}) == ($past(d_i) | ~{DATA_W{sel_i}}));

    // R5 / R4: a row that is not strobed keeps its word
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!(sel_i && wr_i) && sel_i) |=> (!sel_i || tap_o == $past(tap_o)));

endmodule

// File: rtl/xor_merge.sv
module xor_merge #(
    parameter int ROWS   = 1 << ram_pkg::ADDR_W_DEF,
    parameter int DATA_W = ram_pkg::DATA_W_DEF
) (
    input  logic [ROWS-1:0][DATA_W-1:0] taps_i,
    output logic [DATA_W-1:0]           word_o
);

    for (genvar c = 0; c < DATA_W; c++) begin : g_col
        logic [ROWS-1:0] col;
        for (genvar r = 0; r < ROWS; r++) begin : g_bit
            assign col[r] = taps_i[r][c];
        end
        assign word_o[c] = ^col;
    end

endmodule

// File: rtl/word_ram.sv
module word_ram #(
    parameter int ADDR_W = ram_pkg::ADDR_W_DEF,
    parameter int DATA_W = ram_pkg::DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    import ram_pkg::*;

    localparam int ROWS = 1 << ADDR_W;

    typedef struct packed {
        ram_op_e           op;
        logic [DATA_W-1:0] data;
    } access_t;

    access_t                     acc;
    logic [ROWS-1:0]             row_sel;
    logic [ROWS-1:0][DATA_W-1:0] row_tap;
    logic [DATA_W-1:0]           merged;

    assign acc.op   = wr_en ? OP_WRITE : OP_READ;
    assign acc.data = wr_data;

    row_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (addr),
        .sel_o  (row_sel)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        ram_row #(.DATA_W(DATA_W)) u_row (
            .clk   (clk),
            .rst   (rst),
            .sel_i (row_sel[r]),
            .wr_i  (acc.op == OP_WRITE),
            .d_i   (acc.data),
            .tap_o (row_tap[r])
        );
    end

    xor_merge #(.ROWS(ROWS), .DATA_W(DATA_W)) u_merge (
        .taps_i (row_tap),
        .word_o (merged)
    );

    always_ff @(posedge clk) begin
        if (rst)                  rd_data <= '0;
        else if (acc.op == OP_READ) rd_data <= merged;
    end

    // R1: the output is cleared by reset
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> rd_data == '0);

    // R6: the output holds through a write cycle
    p_hold_on_write_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> $stable(rd_data));

    // R3: a read of a just-written address returns the written word
    p_write_then_read_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en ##1 (!wr_en && $stable(addr))) |=> rd_data == $past(wr_data, 2));

endmodule

// File: tb/tb_word_ram.sv
module tb_word_ram;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;

    always #2 clk = ~clk;   // 250 MHz

    word_ram #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    typedef struct {
        logic [DW-1:0] val;
        string         tag;
    } exp_t;

    exp_t          exp_q[$];
    logic [DW-1:0] model [NW];
    logic [DW-1:0] last_rd;
    logic          rd_issue = 1'b0;
    logic          chk_pend = 1'b0;
    int            total = 0;
    int            bad = 0;
    logic          done = 1'b0;

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: a read issued in one cycle is compared at the next falling edge.
    always @(posedge clk) chk_pend <= rd_issue;
    always @(negedge clk) begin
        if (chk_pend && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(rd_data, e.val, e.tag);
        end
    end

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; wr_en = 1'b1; wr_data = d; rd_issue = 1'b0;
        model[a] = d;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string tag);
        exp_t e;
        @(negedge clk);
        addr = a; wr_en = 1'b0; rd_issue = 1'b1;
        e.val = model[a]; e.tag = tag;
        exp_q.push_back(e);
        last_rd = model[a];
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0; rd_issue = 1'b0;
        wr_data = ~wr_data;
    endtask

    initial begin
        for (int i = 0; i < NW; i++) model[i] = '0;
        last_rd = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rd_data, '0, "R1 output after reset");
        for (int i = 0; i < NW; i++) do_read(AW'(i), "R1 cleared word");
        idle();

        // R7 / R2 / R3: distinct address-derived words everywhere
        for (int i = 0; i < NW; i++) do_write(AW'(i), DW'(8'h3C ^ (i * 8'h11)));
        for (int i = 0; i < NW; i++) do_read(AW'(i), "R7 distinct words / R3 read");
        // R4: reading again returns the same words
        for (int i = NW - 1; i >= 0; i--) do_read(AW'(i), "R4 refresh keeps word");
        idle();

        // R2: walking ones, alternating bits, all ones
        for (int b = 0; b < DW; b++) begin
            do_write(AW'(b), DW'(1) << b);
            do_read(AW'(b), "R2 walking one");
        end
        do_write(AW'(NW - 1), 8'h55); do_read(AW'(NW - 1), "R2 alternating 55");
        do_write(AW'(NW - 2), 8'hAA); do_read(AW'(NW - 2), "R2 alternating AA");
        do_write(AW'(0), 8'hFF);      do_read(AW'(0), "R2 all ones");

        // R5: one write, then sweep every address
        do_write(AW'(5), 8'hC3);
        for (int i = 0; i < NW; i++) do_read(AW'(i), "R5 neighbours untouched");

        // R6: output holds while writing
        do_read(AW'(9), "R3 before write");
        do_write(AW'(9), 8'h96);
        @(negedge clk);
        rd_issue = 1'b0;
        check(rd_data, last_rd, "R6 hold during write");
        idle();
        do_read(AW'(9), "R3 after write");
        idle();
        idle();
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R3: actual=%0d pending expected=0", exp_q.size());
        end
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<20000", cyc);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule